// File: doc/BRIEF.md
# Delayed Read Discard Timer

This block guards one delayed read transaction inside a bus bridge target. When the bridge has fetched the read data and that data sits at the head of its outbound queue, the block starts counting clocks and waits for the original requester to come back and retry. A matching retry ends the wait quietly. If the requester stays away for a fixed number of clocks, the block emits a one-cycle discard pulse so that the queue logic can drop the stale entry. It also raises a sticky status flag that software clears by writing a one.

A control input turns the timer off. While it is off, nothing is counted and no discard can happen. Only one transaction is tracked at a time. The queue itself, the bus decode and the work of matching a retry to its original request all sit outside this block. The block sees that matching only as a single pulse.

Top module: `dlyrd_discard_timer`

## Requirements
- R1: After reset, `discard_o` and `discard_stat_o` are 0 and no transaction is being timed.
- R2: A `data_ready_i` pulse sampled while the block is idle and `timer_off_i` is 0 arms the timer with a count of zero.
- R3: If no retry arrives, `discard_o` is high exactly EXPIRE_CYCLES (default 1024) clock edges after the edge that sampled `data_ready_i`. It is high for one cycle only, and the block then returns to idle.
- R4: In the cycle `discard_o` is high, `discard_stat_o` is 1. The flag never rises in any other cycle.
- R5: A `retry_hit_i` pulse sampled while armed cancels the wait without a discard and without touching the status flag. This includes a retry sampled on the last edge before expiry.
- R6: `timer_off_i` = 1 enables nothing and 0 is the enabled state. While it is 1, any armed wait is dropped, `data_ready_i` is ignored and `discard_o` stays 0.
- R7: `discard_stat_o` is sticky. It stays 1 until a write (`stat_wr_i` = 1) with `stat_wdata_i` = 1, and a write with `stat_wdata_i` = 0 leaves it unchanged.
- R8: A write with `stat_wdata_i` = 1 drives `discard_stat_o` to 0 on the next cycle when no expiry happens on the same edge.
- R9: When an expiry and a clearing write fall on the same edge, the set wins and `discard_stat_o` stays 1.
- R10: A further `data_ready_i` while armed is ignored. The deadline is still counted from the first one.
- R11: A `retry_hit_i` while idle has no effect on `discard_o` or `discard_stat_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| data_ready_i | input | 1 | Pulse: read data of the pending transaction reached the queue head |
| retry_hit_i | input | 1 | Pulse: the original requester repeated the transaction |
| timer_off_i | input | 1 | 1 turns the timer off, 0 enables it |
| stat_wr_i | input | 1 | Write strobe for the status flag |
| stat_wdata_i | input | 1 | Write data; 1 clears the flag |
| discard_o | output | 1 | One-cycle pulse telling the queue to drop the entry |
| discard_stat_o | output | 1 | Sticky flag recording that a discard occurred |

## Verification
An expiry and a software clear of the status flag can land on the same clock edge. The bench provokes this by arming the timer and then, on exactly the 1024th edge after arming, driving a write with data 1 together with the edge that expires the count. The result is judged at the ports: the discard pulse must appear on that edge and the flag must still read 1 afterwards. A later plain clear must then bring the flag to 0, which shows that the earlier write was overridden and not simply lost.

// File: rtl/dlyrd_pkg.sv
package dlyrd_pkg;

    typedef enum logic {
        DT_IDLE  = 1'b0,
        DT_ARMED = 1'b1
    } dt_state_e;

    typedef struct packed {
        logic flag;
    } dt_flag_t;

endpackage

// File: rtl/dt_window_ctrl.sv
module dt_window_ctrl
    import dlyrd_pkg::*;
#(
    parameter int EXPIRE_CYCLES = 1024
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic start_i,
    input  logic retry_i,
    input  logic off_i,
    output logic expire_o,
    output logic discard_o
);

    localparam int CNT_W = (EXPIRE_CYCLES > 1) ? $clog2(EXPIRE_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(EXPIRE_CYCLES - 1);

    typedef struct packed {
        dt_state_e        state;
        logic [CNT_W-1:0] cnt;
        logic             discard;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;
    logic  expire;

    always_comb begin
        ctrl_d         = ctrl_q;
        ctrl_d.discard = 1'b0;
        expire         = 1'b0;
        if (off_i) begin
            ctrl_d.state = DT_IDLE;
            ctrl_d.cnt   = '0;
        end else begin
            unique case (ctrl_q.state)
                DT_IDLE: begin
                    ctrl_d.cnt = '0;
                    if (start_i) begin
                        ctrl_d.state = DT_ARMED;
                    end
                end
                DT_ARMED: begin
                    if (retry_i) begin
                        ctrl_d.state = DT_IDLE;
                        ctrl_d.cnt   = '0;
                    end else if (ctrl_q.cnt == LAST) begin
                        expire         = 1'b1;
                        ctrl_d.discard = 1'b1;
                        ctrl_d.state   = DT_IDLE;
                        ctrl_d.cnt     = '0;
                    end else begin
                        ctrl_d.cnt = ctrl_q.cnt + 1'b1;
                    end
                end
                default: begin
                    ctrl_d.state = DT_IDLE;
                    ctrl_d.cnt   = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            ctrl_q <= '{state: DT_IDLE, cnt: '0, discard: 1'b0};
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign expire_o  = expire;
    assign discard_o = ctrl_q.discard;

endmodule

// File: rtl/dt_sticky_flag.sv
module dt_sticky_flag
    import dlyrd_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic set_i,
    input  logic wr_i,
    input  logic wdata_i,
    output logic flag_o
);

    dt_flag_t flag_d, flag_q;

    always_comb begin
        flag_d = flag_q;
        if (wr_i && wdata_i) begin
            flag_d.flag = 1'b0;
        end
        if (set_i) begin
            flag_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            flag_q <= '{flag: 1'b0};
        end else begin
            flag_q <= flag_d;
        end
    end

    assign flag_o = flag_q.flag;

endmodule

// File: rtl/dlyrd_discard_timer.sv
module dlyrd_discard_timer #(
    parameter int EXPIRE_CYCLES = 1024
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic data_ready_i,
    input  logic retry_hit_i,
    input  logic timer_off_i,
    input  logic stat_wr_i,
    input  logic stat_wdata_i,
    output logic discard_o,
    output logic discard_stat_o
);

    logic expire;

    dt_window_ctrl #(
        .EXPIRE_CYCLES(EXPIRE_CYCLES)
    ) i_window (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .start_i  (data_ready_i),
        .retry_i  (retry_hit_i),
        .off_i    (timer_off_i),
        .expire_o (expire),
        .discard_o(discard_o)
    );

    dt_sticky_flag i_flag (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .set_i  (expire),
        .wr_i   (stat_wr_i),
        .wdata_i(stat_wdata_i),
        .flag_o (discard_stat_o)
    );

endmodule

// File: rtl/dlyrd_discard_timer_chk.sv
module dlyrd_discard_timer_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic retry_hit_i,
    input logic timer_off_i,
    input logic stat_wr_i,
    input logic stat_wdata_i,
    input logic expire,
    input logic discard_o,
    input logic discard_stat_o
);

    assert_single_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        discard_o |=> !discard_o);

    assert_flag_with_discard_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        discard_o |-> discard_stat_o);

    assert_flag_rise_only_on_discard_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(discard_stat_o) |-> discard_o);

    assert_retry_blocks_discard_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        retry_hit_i |=> !discard_o);

    assert_off_blocks_discard_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        timer_off_i |=> !discard_o);

    assert_flag_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (discard_stat_o && !(stat_wr_i && stat_wdata_i)) |=> discard_stat_o);

    assert_flag_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stat_wr_i && stat_wdata_i && !expire) |=> !discard_stat_o);

    assert_set_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        expire |=> (discard_stat_o && discard_o));

endmodule

bind dlyrd_discard_timer dlyrd_discard_timer_chk i_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .retry_hit_i   (retry_hit_i),
    .timer_off_i   (timer_off_i),
    .stat_wr_i     (stat_wr_i),
    .stat_wdata_i  (stat_wdata_i),
    .expire        (expire),
    .discard_o     (discard_o),
    .discard_stat_o(discard_stat_o)
);

// File: tb/test_dlyrd_discard_timer.sv
`timescale 1ns/1ps
module test_dlyrd_discard_timer;

    localparam int EXPIRE = 1024;
    localparam int SPAN   = EXPIRE + 60;
    localparam int NVEC   = 8;

    typedef struct packed {
        int req;
        int retry_at;
        int off_at;
        int rdy2_at;
        int clr_at;
        int hold_off;
        int exp_at;
    } vec_t;

    // fields: requirement, retry step, off step, second ready step, clear step, hold off, expected discard step
    localparam vec_t VECS [NVEC] = '{
        '{3,   -1,  -1,  -1,   -1, 0, EXPIRE},  // R3 plain expiry
        '{5,   10,  -1,  -1,   -1, 0, -1},      // R5 early retry
        '{5, EXPIRE, -1, -1,   -1, 0, -1},      // R5 retry on the last edge
        '{11, EXPIRE + 1, -1, -1, -1, 0, EXPIRE}, // R11 retry after discard is ignored
        '{6,   -1, 300,  -1,   -1, 0, -1},      // R6 off pulse drops armed wait
        '{10,  -1,  -1, 500,   -1, 0, EXPIRE},  // R10 second ready ignored
        '{6,   -1,  -1,  -1,   -1, 1, -1},      // R6 held off, ready ignored
        '{9,   -1,  -1,  -1, EXPIRE, 0, EXPIRE} // R9 clear and expiry on same edge
    };

    logic clk = 1'b0;
    logic rst_ni = 1'b0;
    logic data_ready_i = 1'b0;
    logic retry_hit_i = 1'b0;
    logic timer_off_i = 1'b0;
    logic stat_wr_i = 1'b0;
    logic stat_wdata_i = 1'b0;
    logic discard_o;
    logic discard_stat_o;

    int total = 0;
    int passed = 0;

    always #2 clk = ~clk;

    dlyrd_discard_timer #(.EXPIRE_CYCLES(EXPIRE)) i_dlyrd_discard_timer (
        .clk_i         (clk),
        .rst_ni        (rst_ni),
        .data_ready_i  (data_ready_i),
        .retry_hit_i   (retry_hit_i),
        .timer_off_i   (timer_off_i),
        .stat_wr_i     (stat_wr_i),
        .stat_wdata_i  (stat_wdata_i),
        .discard_o     (discard_o),
        .discard_stat_o(discard_stat_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        total++;
        if (ok) passed++;
        else $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    endtask

    task automatic idle_inputs();
        data_ready_i = 1'b0; retry_hit_i = 1'b0; timer_off_i = 1'b0;
        stat_wr_i = 1'b0; stat_wdata_i = 1'b0;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic run_vec(input vec_t v);
        int first;
        int pulses;
        string tag;
        first = -1;
        pulses = 0;
        tag = $sformatf("R%0d", v.req);
        for (int k = 0; k <= SPAN; k++) begin
            data_ready_i = (k == 0) || (k == v.rdy2_at);
            retry_hit_i  = (k == v.retry_at);
            timer_off_i  = (v.hold_off != 0) || (k == v.off_at);
            stat_wr_i    = (k == v.clr_at);
            stat_wdata_i = (k == v.clr_at);
            step();
            if (discard_o) begin
                pulses++;
                if (first < 0) first = k;
            end
        end
        idle_inputs();
        check(first == v.exp_at, {tag, " discard step"}, first, v.exp_at);
        check(pulses == ((v.exp_at >= 0) ? 1 : 0), {tag, " R3 pulse count"}, pulses,
              (v.exp_at >= 0) ? 1 : 0);
        check(discard_stat_o == (v.exp_at >= 0), {tag, " R4 status"}, int'(discard_stat_o),
              (v.exp_at >= 0) ? 1 : 0);
    endtask

    task automatic clear_flag();
        stat_wr_i = 1'b1; stat_wdata_i = 1'b1;
        step();
        idle_inputs();
        check(discard_stat_o == 1'b0, "R8 clear by writing one", int'(discard_stat_o), 0);
    endtask

    initial begin
        repeat (3) step();
        rst_ni = 1'b1;
        step();
        check(discard_o == 1'b0, "R1 discard after reset", int'(discard_o), 0);
        check(discard_stat_o == 1'b0, "R1 status after reset", int'(discard_stat_o), 0);

        // R11: retry while idle changes nothing
        retry_hit_i = 1'b1;
        step();
        idle_inputs();
        step();
        check(discard_o == 1'b0, "R11 idle retry discard", int'(discard_o), 0);
        check(discard_stat_o == 1'b0, "R11 idle retry status", int'(discard_stat_o), 0);

        for (int i = 0; i < NVEC; i++) begin
            run_vec(VECS[i]);
            if (discard_stat_o) clear_flag();
        end

        // R2 and R7: expire once, then a write of zero must leave the flag set
        run_vec('{2, -1, -1, -1, -1, 0, EXPIRE});
        stat_wr_i = 1'b1; stat_wdata_i = 1'b0;
        step();
        idle_inputs();
        step();
        check(discard_stat_o == 1'b1, "R7 write zero keeps flag", int'(discard_stat_o), 1);
        repeat (20) step();
        check(discard_stat_o == 1'b1, "R7 flag holds while idle", int'(discard_stat_o), 1);
        clear_flag();

        $display("%0d/%0d checks passed", passed, total);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", passed, total);
        $finish;
    end

endmodule